// File: doc/BRIEF.md
# Sleep-Mode Clock Gate Sequencer

This block decides when the CPU clock and the internal bus clock of a small processor subsystem may be switched off, and when they come back. Software starts sleep entry by writing a sleep code to a standby control register. The sequencer then waits until the CPU reports that it has released the internal bus. It then drops the CPU clock enable, and drops the bus clock enable one reference-clock cycle later. An enabled peripheral interrupt brings the clocks back in the reverse order: bus first, then CPU. Reset also brings them back.

All decisions are taken on an always-running reference clock, and every gate enable comes straight from a flip-flop. A downstream clock-gating cell therefore sees clean, edge-aligned enables. Sleep entry is refused when the CPU and peripheral divider settings differ. A refused request leaves a sticky error flag that software can read.

Top module: `slp_gate_ctrl`

## Requirements
- R1: A write to the standby register is a sleep request only when data bit 7 is 0 and bit 6 is 1; the other bits are don't-care. Writes with any other combination of these two bits leave both clock enables high.
- R2: After an accepted request both enables stay high while `bus_idle_i` is low, for any number of cycles. At the first clock edge that samples `bus_idle_i` high, `cpu_clk_en_o` goes low.
- R3: On entry `bus_clk_en_o` goes low exactly one cycle after `cpu_clk_en_o`, never before it.
- R4: In full sleep, an edge that samples an interrupt with its enable bit set raises `bus_clk_en_o`. `cpu_clk_en_o` rises one cycle later.
- R5: An interrupt request whose enable bit is 0 has no effect: in sleep, both enables stay low.
- R6: A sleep request written while the two 2-bit gear fields differ is ignored. The clocks stay enabled and `gear_err_o` is set. `gear_err_o` then stays set until reset.
- R7: While `rst_i` is high, both clock enables are high in the same cycle, without waiting for an edge. After a reset edge, `sleep_o` and `gear_err_o` are 0.
- R8: If an enabled interrupt arrives while the request is waiting for bus idle, the request is cancelled and the clocks never stop. If it arrives while only the CPU clock is stopped, the CPU clock is restored at the next edge and the bus clock never stops.
- R9: `sleep_o` is high exactly while `cpu_clk_en_o` is low.
- R10: The two clock enables never change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| stby_wr_i | input | 1 | Write strobe for the standby control register |
| stby_wdata_i | input | 8 | Write data for the standby control register |
| cpu_gear_i | input | 2 | Current CPU clock divider setting |
| per_gear_i | input | 2 | Current peripheral clock divider setting |
| bus_idle_i | input | 1 | CPU reports that it no longer uses the internal bus |
| irq_req_i | input | N_IRQ | Peripheral interrupt requests |
| irq_en_i | input | N_IRQ | Per-peripheral interrupt enables |
| cpu_clk_en_o | output | 1 | Gate enable for the CPU clock |
| bus_clk_en_o | output | 1 | Gate enable for the internal bus clock |
| sleep_o | output | 1 | High while the CPU clock is stopped |
| gear_err_o | output | 1 | Sticky flag for a refused request with mismatched gears |

## Verification
The hardest cases to reach are the aborts in the middle of the stop sequence. One has the interrupt land in the single cycle where only the CPU clock is off. The other has it land while the request is still waiting for bus idle. The bench gets there by holding `bus_idle_i` low for several cycles after the request. It then raises the idle handshake and the enabled interrupt on precise edges, counted from the write. It also checks the reset override in the middle of a cycle, between edges, while the design is in full sleep.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_WAIT    = 3'd1,
        ST_CPU_OFF = 3'd2,
        ST_SLEEP   = 3'd3,
        ST_BUS_ON  = 3'd4
    } slp_state_e;

    typedef struct packed {
        logic cpu_en;
        logic bus_en;
        logic sleep;
    } gate_t;

    localparam gate_t GATE_RUN = '{cpu_en: 1'b1, bus_en: 1'b1, sleep: 1'b0};

    function automatic gate_t gate_of(slp_state_e st);
        gate_t g;
        g = GATE_RUN;
        case (st)
            ST_CPU_OFF, ST_BUS_ON: g = '{cpu_en: 1'b0, bus_en: 1'b1, sleep: 1'b1};
            ST_SLEEP:              g = '{cpu_en: 1'b0, bus_en: 1'b0, sleep: 1'b1};
            default:               g = GATE_RUN;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/slp_req_dec.sv
module slp_req_dec #(
    parameter int REG_W    = 8,
    parameter int GEAR_W   = 2,
    parameter int REQ_BIT  = 6,
    parameter int STOP_BIT = 7
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [GEAR_W-1:0] cpu_gear_i,
    input  logic [GEAR_W-1:0] per_gear_i,
    input  logic              accept_i,
    output logic              req_o,
    output logic              err_o
);
    logic code_hit;
    logic gear_ok;
    logic err_q;

    assign code_hit = wr_i && accept_i && wdata_i[REQ_BIT] && !wdata_i[STOP_BIT];
    assign gear_ok  = (cpu_gear_i == per_gear_i);
    assign req_o    = code_hit && gear_ok;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            err_q <= 1'b0;
        end else if (code_hit && !gear_ok) begin
            err_q <= 1'b1;
        end
    end

    assign err_o = err_q;
endmodule

// File: rtl/slp_wake_det.sv
module slp_wake_det #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_req_i,
    input  logic [N_IRQ-1:0] irq_en_i,
    output logic             wake_o
);
    logic [N_IRQ-1:0] live;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_mask
        assign live[i] = irq_req_i[i] & irq_en_i[i];
    end

    assign wake_o = |live;
endmodule

// File: rtl/slp_seq_fsm.sv
module slp_seq_fsm
    import slp_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  req_i,
    input  logic  idle_i,
    input  logic  wake_i,
    output gate_t gate_o,
    output logic  run_o
);
    slp_state_e st_q, st_d;
    gate_t      gate_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_RUN:     if (req_i)       st_d = ST_WAIT;
            ST_WAIT:    if (wake_i)      st_d = ST_RUN;
                        else if (idle_i) st_d = ST_CPU_OFF;
            ST_CPU_OFF: if (wake_i)      st_d = ST_RUN;
                        else             st_d = ST_SLEEP;
            ST_SLEEP:   if (wake_i)      st_d = ST_BUS_ON;
            ST_BUS_ON:                   st_d = ST_RUN;
            default:                     st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= ST_RUN;
            gate_q <= GATE_RUN;
        end else begin
            st_q   <= st_d;
            gate_q <= gate_of(st_d);
        end
    end

    assign gate_o = gate_q;
    assign run_o  = (st_q == ST_RUN);
endmodule

// File: rtl/slp_gate_ctrl.sv
module slp_gate_ctrl
    import slp_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int REG_W  = 8,
    parameter int GEAR_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              stby_wr_i,
    input  logic [REG_W-1:0]  stby_wdata_i,
    input  logic [GEAR_W-1:0] cpu_gear_i,
    input  logic [GEAR_W-1:0] per_gear_i,
    input  logic              bus_idle_i,
    input  logic [N_IRQ-1:0]  irq_req_i,
    input  logic [N_IRQ-1:0]  irq_en_i,
    output logic              cpu_clk_en_o,
    output logic              bus_clk_en_o,
    output logic              sleep_o,
    output logic              gear_err_o
);
    logic  req;
    logic  wake;
    logic  run;
    gate_t gate;

    slp_req_dec #(
        .REG_W  (REG_W),
        .GEAR_W (GEAR_W)
    ) dec_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_i       (stby_wr_i),
        .wdata_i    (stby_wdata_i),
        .cpu_gear_i (cpu_gear_i),
        .per_gear_i (per_gear_i),
        .accept_i   (run),
        .req_o      (req),
        .err_o      (gear_err_o)
    );

    slp_wake_det #(
        .N_IRQ (N_IRQ)
    ) wake_i (
        .irq_req_i (irq_req_i),
        .irq_en_i  (irq_en_i),
        .wake_o    (wake)
    );

    slp_seq_fsm fsm_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_i  (req),
        .idle_i (bus_idle_i),
        .wake_i (wake),
        .gate_o (gate),
        .run_o  (run)
    );

    assign cpu_clk_en_o = gate.cpu_en | rst_i;
    assign bus_clk_en_o = gate.bus_en | rst_i;
    assign sleep_o      = gate.sleep & ~rst_i;
endmodule

// File: rtl/slp_gate_ctrl_chk.sv
module slp_gate_ctrl_chk #(
    parameter int N_IRQ = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             bus_idle_i,
    input logic [N_IRQ-1:0] irq_req_i,
    input logic [N_IRQ-1:0] irq_en_i,
    input logic             cpu_clk_en_o,
    input logic             bus_clk_en_o,
    input logic             sleep_o,
    input logic             gear_err_o
);
    // R2
    idle_wait_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bus_idle_i && cpu_clk_en_o) |=> cpu_clk_en_o);

    // R3
    cpu_first_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(bus_clk_en_o) |-> $past(!cpu_clk_en_o));

    // R4
    bus_first_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cpu_clk_en_o) |-> $past(bus_clk_en_o));

    // R5
    masked_irq_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!(|(irq_req_i & irq_en_i)) && !bus_clk_en_o) |=> !bus_clk_en_o);

    // R6
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        gear_err_o |=> gear_err_o);

    // R9
    sleep_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sleep_o == !cpu_clk_en_o);

    // R10
    one_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $stable(cpu_clk_en_o) || $stable(bus_clk_en_o));

    // R7
    always @(negedge clk_i) begin
        if (rst_i) begin
            rst_force_chk: assert (cpu_clk_en_o && bus_clk_en_o);
        end
    end
endmodule

bind slp_gate_ctrl slp_gate_ctrl_chk #(.N_IRQ(N_IRQ)) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .bus_idle_i   (bus_idle_i),
    .irq_req_i    (irq_req_i),
    .irq_en_i     (irq_en_i),
    .cpu_clk_en_o (cpu_clk_en_o),
    .bus_clk_en_o (bus_clk_en_o),
    .sleep_o      (sleep_o),
    .gear_err_o   (gear_err_o)
);

// File: tb/slp_gate_ctrl_tb.sv
module slp_gate_ctrl_tb_top;
    localparam int N_IRQ = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             wr;
    logic [7:0]       wdata;
    logic [1:0]       cgear, pgear;
    logic             idle;
    logic [N_IRQ-1:0] irq, ien;
    logic             cpu_en, bus_en, slp, err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    slp_gate_ctrl #(.N_IRQ(N_IRQ)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .stby_wr_i    (wr),
        .stby_wdata_i (wdata),
        .cpu_gear_i   (cgear),
        .per_gear_i   (pgear),
        .bus_idle_i   (idle),
        .irq_req_i    (irq),
        .irq_en_i     (ien),
        .cpu_clk_en_o (cpu_en),
        .bus_clk_en_o (bus_en),
        .sleep_o      (slp),
        .gear_err_o   (err)
    );

    // expected packed as {cpu_en, bus_en, sleep, err}
    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {cpu_en, bus_en, slp, err};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] d);
        wr = 1'b1; wdata = d;
        step();
        wr = 1'b0; wdata = 8'h00;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R7 reset state", 4'b1100);
    endtask

    task automatic t_bad_codes();
        write_reg(8'h00); step(3); chk("R1 code 00", 4'b1100);
        write_reg(8'hC0); step(3); chk("R1 code C0", 4'b1100);
        write_reg(8'h80); idle = 1'b1; step(3); chk("R1 code 80", 4'b1100);
        idle = 1'b0;
    endtask

    task automatic t_entry_exit(input logic [7:0] code, input string tag);
        write_reg(code);
        chk({tag, " R2 waiting"}, {2'b11, 1'b0, err});
        step(5);
        chk({tag, " R2 busy 5 cycles"}, {2'b11, 1'b0, err});
        idle = 1'b1;
        step();
        chk({tag, " R2/R9 cpu off"}, {2'b01, 1'b1, err});
        step();
        chk({tag, " R3 bus off"}, {2'b00, 1'b1, err});
        irq = 8'h10; ien = 8'hEF;
        step(4);
        chk({tag, " R5 masked irq"}, {2'b00, 1'b1, err});
        ien = 8'h10;
        step();
        chk({tag, " R4 bus back"}, {2'b01, 1'b1, err});
        irq = 8'h00;
        step();
        chk({tag, " R4 cpu back"}, {2'b11, 1'b0, err});
        idle = 1'b0; ien = 8'h00;
        step(2);
    endtask

    task automatic t_mismatch();
        cgear = 2'b01; pgear = 2'b11;
        write_reg(8'h40);
        idle = 1'b1;
        step(3);
        chk("R6 mismatch refused", 4'b1101);
        idle = 1'b0; cgear = 2'b11;
        step(3);
        chk("R6 error sticky", 4'b1101);
    endtask

    task automatic t_abort_wait();
        write_reg(8'h40);
        step(2);
        irq = 8'h01; ien = 8'h01;
        step();
        irq = 8'h00;
        idle = 1'b1;
        step(3);
        chk("R8 abort while waiting", {3'b110, err});
        idle = 1'b0;
    endtask

    task automatic t_abort_cpu_off();
        write_reg(8'h40);
        idle = 1'b1;
        step();
        chk("R8 cpu off before abort", {3'b011, err});
        irq = 8'h02; ien = 8'h02;
        step();
        chk("R8 cpu restored bus kept", {3'b110, err});
        irq = 8'h00; idle = 1'b0;
        step(2);
        chk("R8 stays running", {3'b110, err});
    endtask

    task automatic t_reset_in_sleep();
        write_reg(8'h40);
        idle = 1'b1;
        step(2);
        chk("R7 in sleep before reset", {3'b001, err});
        rst = 1'b1;
        #1;
        checks++;
        if (!(cpu_en && bus_en)) begin
            errors++;
            $display("FAIL R7 immediate enable act=%b%b exp=11", cpu_en, bus_en);
        end
        step();
        rst = 1'b0; idle = 1'b0;
        chk("R7 cleared after reset", 4'b1100);
    endtask

    initial begin
        rst = 1'b1; wr = 1'b0; wdata = '0; cgear = 2'b10; pgear = 2'b10;
        idle = 1'b0; irq = '0; ien = '0;
        step();
        t_reset();
        t_bad_codes();
        t_entry_exit(8'h40, "R1 plain");
        t_entry_exit(8'h7F, "R1 other bits");
        t_mismatch();
        t_entry_exit(8'h40, "R6 after error");
        t_abort_wait();
        t_abort_cpu_off();
        t_reset_in_sleep();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule